// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block listens to the clock and data lines of a shared I2C bus and picks out the START and STOP conditions on them. It keeps two flags that cannot both be set. One shows that a START was the last condition seen and the other shows that a STOP was. From these flags it produces a bus-free indication, which a node uses to decide whether it may claim the bus. It also keeps a sticky interrupt request.

The interrupt request is raised on each START and each STOP. It is also raised when a companion shifter reports a completed byte, and that byte may be an address byte or a data byte. A source vector records which kinds of event have raised the request since the last clear, so that firmware can tell the causes apart. A node that is waiting for a busy bus sees the STOP raise the request and learns from it that the bus is free.

Clearing the enable input puts the block back in its reset state and makes it ignore all activity. The bus lines pass through a synchronizer inside the block. The byte strobes must already be in the block's clock domain.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After reset, and in every cycle after enable_i is low, start_flag_o, stop_flag_o, irq_o and irq_src_o are all 0. While the block is disabled, bus conditions and byte strobes have no effect.
- R2: A START is SDA falling between two consecutive synchronized samples while SCL is high in both samples. A START sets start_flag_o and clears stop_flag_o.
- R3: A STOP is SDA rising between two consecutive synchronized samples while SCL is high in both samples. A STOP sets stop_flag_o and clears start_flag_o.
- R4: start_flag_o and stop_flag_o are never 1 together. A repeated START, seen while start_flag_o is already set, keeps start_flag_o at 1 and raises the interrupt request again.
- R5: bus_free_o is 1 when stop_flag_o is 1 or when both flags are 0. It is 0 while start_flag_o is 1.
- R6: irq_o is set by a START, a STOP, or a byte_done_i pulse while the block is enabled. irq_src_o records the cause: bit 0 for START, bit 1 for STOP, bit 2 for a byte with byte_is_addr_i=1, and bit 3 for a byte with byte_is_addr_i=0.
- R7: irq_o and irq_src_o keep their values until irq_clear_i is pulsed. When a clear and an event arrive in the same cycle, irq_o stays 1 and irq_src_o then holds only the bit of the new event.
- R8: No condition is detected when SDA changes while SCL is low. No condition is detected when SCL and SDA change between the same two samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| enable_i | input | 1 | Module enable; when low the block is held in its reset state |
| byte_done_i | input | 1 | One-cycle strobe from the shifter when a byte is complete |
| byte_is_addr_i | input | 1 | Qualifies byte_done_i: 1 for an address byte, 0 for a data byte |
| irq_clear_i | input | 1 | One-cycle pulse that clears irq_o and irq_src_o |
| start_flag_o | output | 1 | The last condition seen was a START |
| stop_flag_o | output | 1 | The last condition seen was a STOP |
| bus_free_o | output | 1 | The bus may be claimed by this node |
| irq_o | output | 1 | Sticky interrupt request |
| irq_src_o | output | 4 | Sticky interrupt causes: START, STOP, address byte, data byte |

## Verification
Directed line sequences separate the cases. A START and a STOP each show the flags swapping. A START repeated without a STOP in between must keep the start flag and raise a fresh interrupt. An SDA change while SCL is low, and a change of both lines between the same two samples, must leave every output unchanged, which shows the detector needs SCL high in both samples. A byte strobe that arrives in the same cycle as a clear shows that the event wins and that the source vector restarts from the new cause. Disabling the block while the lines keep moving shows that activity is ignored. A long random mix of line levels, byte strobes, clears and enable changes is then compared against a bench model of the flags, the interrupt and the source vector.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned SRC_START = 0;
  localparam int unsigned SRC_STOP  = 1;
  localparam int unsigned SRC_ADDR  = 2;
  localparam int unsigned SRC_DATA  = 3;

  typedef struct packed {
    logic start;
    logic stop;
  } cond_t;
endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
  parameter int unsigned WIDTH     = 2,
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RESET_VAL}};
      else if (STAGES > 1) chain_q <= {chain_q[STAGES-2:0], d_i[b]};
      else chain_q <= d_i[b];
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/i2cmon_cond_detect.sv
module i2cmon_cond_detect
  import i2cmon_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  scl_i,
  input  logic  sda_i,
  output cond_t cond_o
);
  logic scl_q, sda_q;

  // idle bus is high on both lines
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  logic scl_held;
  assign scl_held     = scl_q & scl_i;
  assign cond_o.start = scl_held &  sda_q & ~sda_i;
  assign cond_o.stop  = scl_held & ~sda_q &  sda_i;

  AST_COND_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cond_o.start && cond_o.stop)); // R4
  AST_SCL_LOW_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_i || !scl_q) |-> !(cond_o.start || cond_o.stop)); // R8
endmodule

// File: rtl/i2cmon_event_reg.sv
module i2cmon_event_reg
  import i2cmon_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  cond_t              cond_i,
  input  logic               byte_done_i,
  input  logic               byte_is_addr_i,
  input  logic               irq_clear_i,
  output logic               start_flag_o,
  output logic               stop_flag_o,
  output logic               bus_free_o,
  output logic               irq_o,
  output logic [NUM_SRC-1:0] irq_src_o
);
  logic [NUM_SRC-1:0] ev;

  always_comb begin
    ev            = '0;
    ev[SRC_START] = cond_i.start;
    ev[SRC_STOP]  = cond_i.stop;
    ev[SRC_ADDR]  = byte_done_i &  byte_is_addr_i;
    ev[SRC_DATA]  = byte_done_i & ~byte_is_addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_flag_o <= 1'b0;
      stop_flag_o  <= 1'b0;
      irq_o        <= 1'b0;
      irq_src_o    <= '0;
    end else if (!enable_i) begin
      start_flag_o <= 1'b0;
      stop_flag_o  <= 1'b0;
      irq_o        <= 1'b0;
      irq_src_o    <= '0;
    end else begin
      if (cond_i.start) begin
        start_flag_o <= 1'b1;
        stop_flag_o  <= 1'b0;
      end else if (cond_i.stop) begin
        start_flag_o <= 1'b0;
        stop_flag_o  <= 1'b1;
      end
      // new events take priority over a same-cycle clear
      irq_src_o <= (irq_clear_i ? '0 : irq_src_o) | ev;
      irq_o     <= (|ev) | (irq_o & ~irq_clear_i);
    end
  end

  assign bus_free_o = stop_flag_o | ~(start_flag_o | stop_flag_o);

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_flag_o && stop_flag_o)); // R4
  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !start_flag_o && !stop_flag_o && !irq_o && irq_src_o == '0); // R1
  AST_START_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && cond_i.start) |=> start_flag_o && !stop_flag_o); // R2
  AST_STOP_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && cond_i.stop) |=> stop_flag_o && !start_flag_o); // R3
  AST_EVENT_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && (byte_done_i || cond_i.start || cond_i.stop)) |=> irq_o); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && irq_o && !irq_clear_i) |=> irq_o); // R7
  AST_FREE_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_flag_o |-> !bus_free_o); // R5
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2cmon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               enable_i,
  input  logic               byte_done_i,
  input  logic               byte_is_addr_i,
  input  logic               irq_clear_i,
  output logic               start_flag_o,
  output logic               stop_flag_o,
  output logic               bus_free_o,
  output logic               irq_o,
  output logic [NUM_SRC-1:0] irq_src_o
);
  localparam int unsigned LINES = 2;

  logic [LINES-1:0] lines_sync;
  cond_t            cond;

  i2cmon_sync #(
    .WIDTH    (LINES),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_sync)
  );

  i2cmon_cond_detect u_detect (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (lines_sync[1]),
    .sda_i (lines_sync[0]),
    .cond_o(cond)
  );

  i2cmon_event_reg u_events (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enable_i      (enable_i),
    .cond_i        (cond),
    .byte_done_i   (byte_done_i),
    .byte_is_addr_i(byte_is_addr_i),
    .irq_clear_i   (irq_clear_i),
    .start_flag_o  (start_flag_o),
    .stop_flag_o   (stop_flag_o),
    .bus_free_o    (bus_free_o),
    .irq_o         (irq_o),
    .irq_src_o     (irq_src_o)
  );
endmodule

// File: tb/i2c_bus_monitor_test.sv
`timescale 1ns/1ps
module i2c_bus_monitor_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl = 1'b1, sda = 1'b1, en = 1'b0;
  logic bdone = 1'b0, baddr = 1'b0, clr = 1'b0;
  logic start_f, stop_f, free_o, irq;
  logic [3:0] src;

  int checks = 0, failures = 0;
  bit done = 0;

  logic es = 0, ep = 0, eirq = 0;
  logic [3:0] esrc = '0;

  always #5 clk = ~clk;

  i2c_bus_monitor uut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda), .enable_i(en),
    .byte_done_i(bdone), .byte_is_addr_i(baddr), .irq_clear_i(clr),
    .start_flag_o(start_f), .stop_flag_o(stop_f), .bus_free_o(free_o),
    .irq_o(irq), .irq_src_o(src)
  );

  function automatic logic [7:0] exp_vec();
    logic f;
    f = ep | ~(es | ep);
    return {esrc, eirq, f, ep, es};
  endfunction

  task automatic check(input string tag);
    logic [7:0] act;
    act = {src, irq, free_o, stop_f, start_f};
    checks++;
    if (act !== exp_vec()) begin
      failures++;
      $display("FAIL %s: act src/irq/free/stop/start=%b exp=%b", tag, act, exp_vec());
    end
  endtask

  task automatic set_lines(input logic nscl, input logic nsda, input string tag);
    if (en && scl && nscl && (sda != nsda)) begin
      if (!nsda) begin es = 1; ep = 0; esrc[0] = 1; end
      else begin ep = 1; es = 0; esrc[1] = 1; end
      eirq = 1;
    end
    @(negedge clk);
    scl = nscl; sda = nsda;
    repeat (4) @(negedge clk);
    check(tag);
  endtask

  task automatic pulse(input logic bd, input logic ba, input logic cl, input string tag);
    @(negedge clk);
    bdone = bd; baddr = ba; clr = cl;
    if (en) begin
      if (cl) esrc = '0;
      if (bd) esrc[ba ? 2 : 3] = 1;
      eirq = bd | (eirq & ~cl);
    end
    @(negedge clk);
    bdone = 0; clr = 0;
    @(negedge clk);
    check(tag);
  endtask

  task automatic set_en(input logic v, input string tag);
    @(negedge clk);
    en = v;
    if (!v) begin es = 0; ep = 0; eirq = 0; esrc = '0; end
    repeat (4) @(negedge clk);
    check(tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: act=timeout exp=finish");
    summary();
  end

  initial begin
    int unsigned r;
    r = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check("R1 reset");
    set_en(1, "R1 enable idle");
    set_lines(1, 0, "R2 start");
    pulse(0, 0, 1, "R7 clear after start");
    set_lines(0, 0, "R8 scl low");
    set_lines(0, 1, "R8 sda rise scl low");
    set_lines(1, 1, "R8 scl rise");
    set_lines(1, 0, "R4 repeated start");
    set_lines(0, 0, "R8 scl low again");
    set_lines(1, 0, "R5 busy");
    set_lines(1, 1, "R3 stop");
    check("R5 free after stop");
    pulse(0, 0, 1, "R7 clear");
    set_lines(0, 0, "R8 both change");
    set_lines(1, 1, "R8 both change back");
    pulse(1, 1, 0, "R6 addr byte");
    pulse(1, 0, 0, "R6 data byte");
    pulse(0, 0, 0, "R7 hold");
    pulse(1, 1, 1, "R7 event beats clear");
    set_en(0, "R1 disable");
    set_lines(1, 0, "R1 start ignored");
    pulse(1, 0, 0, "R1 byte ignored");
    set_lines(1, 1, "R1 stop ignored");
    set_en(1, "R1 reenable");
    for (int i = 0; i < 3000; i++) begin
      r = $urandom % 16;
      if (r < 11) set_lines(1'($urandom), 1'($urandom), "R4 random lines");
      else if (r < 13) pulse(1, 1'($urandom), 0, "R6 random byte");
      else if (r == 13) pulse(0, 0, 1, "R7 random clear");
      else if (r == 14) pulse(1, 1'($urandom), 1, "R7 random byte+clear");
      else if ($urandom % 4 == 0) set_en(~en, "R1 random enable");
      else set_lines(scl, ~sda, "R2 random sda toggle");
    end
    summary();
  end
endmodule